// File: doc/BRIEF.md
# Beam-Synchronized Scanline Timing Generator

This block is the timing core of a video system that keeps no pixel storage and draws each line straight from whatever the processor has just written. It runs on the colour clock. It counts colour clocks along each scanline and counts scanlines down the frame. From those counts it derives horizontal sync and blanking, vertical blanking, a frame phase code and a flag for the visible region. It also produces the processor's clock enable, which is one colour clock in three.

Software owns vertical sync. A write of 1 to the sync register opens the sync interval, and a write of 0 closes it. Closing the interval restarts the scanline count at zero, so the vertical blank, visible and overscan regions are counted from that moment. Any write to the line-wait register halts the processor. The halt holds until the first colour clock of the next scanline, which lets software line its register updates up with the beam.

Top module: `beam_timing_gen`

## Requirements
- R1: After reset, the colour-clock position `hpos` increments by one on every clock, from 0 up to 227, and then returns to 0. The scanline number `line_num` advances by one on the clock where `hpos` returns from 227 to 0.
- R2: `hblank` is high exactly while `hpos` is between 160 and 227 inclusive. `hsync` is high exactly while `hpos` is between 176 and 191 inclusive.
- R3: `cpu_ce` is high exactly when `hpos` modulo 3 equals 2. It is therefore high on one colour clock in three, and on the last clock of every line.
- R4: A write is taken only when `wr_en`, `cpu_ce` and `cpu_ready` are all high on the same clock. When `wr_sel` is 0, the write stores `wr_data` in the sync register, and `vsync` shows the new value from the following clock. A write on a clock where `cpu_ce` is low has no effect on `vsync`.
- R5: A taken write of 0 while `vsync` is high sets `line_num` to 0 on the next clock. This holds even when the write falls on the last clock of a line.
- R6: `phase` takes one of four codes:
  - 0 (sync) while `vsync` is high.
  - Otherwise 1 (vertical blank) for lines 0 to 36.
  - 2 (visible) for lines 37 to 228.
  - 3 (overscan) from line 229 on.

  `vblank` is high whenever `phase` is not 2. `visible` is high exactly when `phase` is 2.
- R7: A taken write with `wr_sel` 1 pulls `cpu_ready` low from the next clock, whatever the value of `wr_data`. `cpu_ready` stays low through clock 227 of that line and is high again at `hpos` 0 of the next line.
- R8: A line-wait write taken at `hpos` 227 keeps `cpu_ready` low through the whole of the following line. `cpu_ready` is high again at `hpos` 0 of the line after that.
- R9: While `cpu_ready` is low, every write is ignored, including writes to the sync register.
- R10: After reset, `hpos` is 0, `line_num` is 0, `vsync` is 0, `cpu_ready` is 1 and `phase` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Colour clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Processor register write request |
| wr_sel | input | 1 | Register select: 0 selects the sync register, 1 selects the line-wait strobe |
| wr_data | input | 1 | Write data bit (used only by the sync register) |
| cpu_ce | output | 1 | Processor clock enable, one colour clock in three |
| cpu_ready | output | 1 | Low while the processor is halted by a line wait |
| hpos | output | 8 | Colour-clock position within the line |
| line_num | output | 9 | Scanline count since the end of the last vertical sync |
| hsync | output | 1 | Horizontal sync pulse |
| hblank | output | 1 | Horizontal blanking |
| vsync | output | 1 | Vertical sync, as set by software |
| vblank | output | 1 | High outside the visible region |
| visible | output | 1 | High inside the visible region |
| phase | output | 2 | Frame phase: 0 sync, 1 vertical blank, 2 visible, 3 overscan |

## Verification
Two events can land on the final colour clock of a line. One is a line-wait strobe arriving on the same clock that would otherwise release the halt. The other is the end of vertical sync arriving on the same clock as the scanline increment. The bench places a write exactly at `hpos` 227 for each case. For the strobe, it expects the halt to span the whole next line. For the end of sync, it expects the line count to read 0 rather than one more. A behavioural reference model, compared on every clock, judges both cases, and directed checks at the line edges confirm them.

// File: rtl/beam_pkg.sv
package beam_pkg;
    typedef enum logic [1:0] {
        PH_SYNC     = 2'd0,
        PH_VBLANK   = 2'd1,
        PH_VISIBLE  = 2'd2,
        PH_OVERSCAN = 2'd3
    } beam_phase_e;
endpackage

// File: rtl/beam_hcnt.sv
module beam_hcnt #(
    parameter int LINE_CLKS   = 228,
    parameter int HBLANK_CLKS = 68,
    parameter int HSYNC_OFS   = 16,
    parameter int HSYNC_LEN   = 16,
    parameter int CPU_DIV     = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    output logic [$clog2(LINE_CLKS)-1:0] hpos,
    output logic                         line_end,
    output logic                         hblank,
    output logic                         hsync,
    output logic                         cpu_ce
);
    localparam int HW = $clog2(LINE_CLKS);
    localparam int DW = (CPU_DIV > 1) ? $clog2(CPU_DIV) : 1;
    localparam logic [HW-1:0] H_LAST   = HW'(LINE_CLKS - 1);
    localparam logic [HW-1:0] HB_START = HW'(LINE_CLKS - HBLANK_CLKS);
    localparam logic [HW-1:0] HS_START = HW'(LINE_CLKS - HBLANK_CLKS + HSYNC_OFS);
    localparam logic [HW-1:0] HS_END   = HW'(LINE_CLKS - HBLANK_CLKS + HSYNC_OFS + HSYNC_LEN);
    localparam logic [DW-1:0] DIV_LAST = DW'(CPU_DIV - 1);

    typedef struct packed {
        logic [HW-1:0] hpos;
        logic [DW-1:0] div;
    } hstate_t;

    hstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.hpos = (st_q.hpos == H_LAST) ? '0 : st_q.hpos + 1'b1;
        st_d.div  = (st_q.div == DIV_LAST) ? '0 : st_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hpos     = st_q.hpos;
    assign line_end = (st_q.hpos == H_LAST);
    assign hblank   = (st_q.hpos >= HB_START);
    assign hsync    = (st_q.hpos >= HS_START) && (st_q.hpos < HS_END);
    assign cpu_ce   = (st_q.div == DIV_LAST);

    // R1: the line position returns to zero after its last clock
    p_hpos_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (hpos == '0));
    // R2: blanking begins at its configured position
    p_hblank_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hblank) |-> (hpos == HB_START));
    // R3: the processor enable is never high on two clocks in a row
    p_ce_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ce |=> !cpu_ce);
endmodule

// File: rtl/beam_cpu_port.sv
module beam_cpu_port (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_sel,
    input  logic wr_data,
    input  logic cpu_ce,
    input  logic line_end,
    output logic vsync,
    output logic vs_fall,
    output logic cpu_ready
);
    typedef struct packed {
        logic vs;
        logic halt;
    } pstate_t;

    pstate_t st_d, st_q;
    logic    take;

    always_comb begin
        take    = wr_en && cpu_ce && !st_q.halt;
        vs_fall = take && !wr_sel && !wr_data && st_q.vs;
        st_d    = st_q;
        if (take && !wr_sel) st_d.vs = wr_data;
        if (take && wr_sel)  st_d.halt = 1'b1;
        else if (line_end)   st_d.halt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vsync     = st_q.vs;
    assign cpu_ready = !st_q.halt;

    // R7: a halted processor is released at the line boundary
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ready && line_end) |=> cpu_ready);
    // R8: a strobe on the last clock keeps the halt into the new line
    p_late_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && cpu_ce && cpu_ready && line_end) |=> !cpu_ready);
    // R9: sync register is frozen while halted
    p_halt_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |=> $stable(vsync));
    // R4: no enable, no change
    p_vs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && cpu_ce) |=> $stable(vsync));
endmodule

// File: rtl/beam_vcnt.sv
module beam_vcnt
    import beam_pkg::*;
#(
    parameter int LINE_W        = 9,
    parameter int VBLANK_LINES  = 37,
    parameter int VISIBLE_LINES = 192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic              vs_fall,
    input  logic              vsync,
    output logic [LINE_W-1:0] line_num,
    output beam_phase_e       phase
);
    localparam logic [LINE_W-1:0] VIS_FIRST = LINE_W'(VBLANK_LINES);
    localparam logic [LINE_W-1:0] VIS_END   = LINE_W'(VBLANK_LINES + VISIBLE_LINES);
    localparam logic [LINE_W-1:0] LINE_MAX  = '1;

    typedef struct packed {
        logic [LINE_W-1:0] line;
    } vstate_t;

    vstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vs_fall)
            st_d.line = '0;
        else if (line_end && st_q.line != LINE_MAX)
            st_d.line = st_q.line + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (vsync)                  phase = PH_SYNC;
        else if (st_q.line < VIS_FIRST) phase = PH_VBLANK;
        else if (st_q.line < VIS_END)   phase = PH_VISIBLE;
        else                        phase = PH_OVERSCAN;
    end

    assign line_num = st_q.line;

    // R5: end of vertical sync restarts the line count, even at a wrap
    p_line_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vs_fall |=> (line_num == '0));
    // R1: a line boundary without sync end advances the count
    p_line_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !vs_fall && line_num != LINE_MAX) |=> (line_num == $past(line_num) + 1'b1));
    // R6: the visible region is entered only from vertical blank
    p_vis_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_VISIBLE && $past(phase) != PH_VISIBLE) |-> ($past(phase) == PH_VBLANK || $past(phase) == PH_SYNC));
endmodule

// File: rtl/beam_timing_gen.sv
module beam_timing_gen
    import beam_pkg::*;
#(
    parameter int LINE_CLKS     = 228,
    parameter int HBLANK_CLKS   = 68,
    parameter int HSYNC_OFS     = 16,
    parameter int HSYNC_LEN     = 16,
    parameter int CPU_DIV       = 3,
    parameter int LINE_W        = 9,
    parameter int VBLANK_LINES  = 37,
    parameter int VISIBLE_LINES = 192
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_sel,
    input  logic                         wr_data,
    output logic                         cpu_ce,
    output logic                         cpu_ready,
    output logic [$clog2(LINE_CLKS)-1:0] hpos,
    output logic [LINE_W-1:0]            line_num,
    output logic                         hsync,
    output logic                         hblank,
    output logic                         vsync,
    output logic                         vblank,
    output logic                         visible,
    output logic [1:0]                   phase
);
    logic        line_end;
    logic        vs_fall;
    beam_phase_e ph;

    beam_hcnt #(
        .LINE_CLKS(LINE_CLKS), .HBLANK_CLKS(HBLANK_CLKS),
        .HSYNC_OFS(HSYNC_OFS), .HSYNC_LEN(HSYNC_LEN), .CPU_DIV(CPU_DIV)
    ) u_hcnt (
        .clk(clk), .rst_n(rst_n), .hpos(hpos), .line_end(line_end),
        .hblank(hblank), .hsync(hsync), .cpu_ce(cpu_ce)
    );

    beam_cpu_port u_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cpu_ce(cpu_ce), .line_end(line_end),
        .vsync(vsync), .vs_fall(vs_fall), .cpu_ready(cpu_ready)
    );

    beam_vcnt #(
        .LINE_W(LINE_W), .VBLANK_LINES(VBLANK_LINES), .VISIBLE_LINES(VISIBLE_LINES)
    ) u_vcnt (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .vs_fall(vs_fall),
        .vsync(vsync), .line_num(line_num), .phase(ph)
    );

    assign phase   = ph;
    assign visible = (ph == PH_VISIBLE);
    assign vblank  = !visible;

    // R6: sync phase always reports as outside the visible region
    p_sync_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> (vblank && !visible));
    // R7: the processor enable keeps pulsing while halted
    p_ce_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ready && hpos == 8'd2) |-> cpu_ce);
endmodule

// File: tb/beam_timing_gen_bench.sv
module beam_timing_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic       wr_data = 1'b0;
    logic       cpu_ce, cpu_ready, hsync, hblank, vsync, vblank, visible;
    logic [7:0] hpos;
    logic [8:0] line_num;
    logic [1:0] phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_h, m_line, m_div;
    bit m_vs, m_halt;
    bit m_take, m_fall, m_end;

    always #4 clk = ~clk;

    beam_timing_gen u_beam_timing_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cpu_ce(cpu_ce), .cpu_ready(cpu_ready), .hpos(hpos), .line_num(line_num),
        .hsync(hsync), .hblank(hblank), .vsync(vsync), .vblank(vblank),
        .visible(visible), .phase(phase)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_h = 0; m_line = 0; m_div = 0; m_vs = 0; m_halt = 0;
        end else begin
            m_take = wr_en && (m_div == 2) && !m_halt;
            m_end  = (m_h == 227);
            m_fall = m_take && !wr_sel && !wr_data && m_vs;
            if (m_take && !wr_sel) m_vs = wr_data;
            if (m_take && wr_sel) m_halt = 1;
            else if (m_end) m_halt = 0;
            if (m_fall) m_line = 0;
            else if (m_end && m_line < 511) m_line = m_line + 1;
            m_h = (m_h + 1) % 228;
            m_div = (m_div + 1) % 3;
        end
    end

    function automatic int exp_phase();
        if (m_vs) return 0;
        if (m_line < 37) return 1;
        if (m_line < 229) return 2;
        return 3;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (hpos=%0d line=%0d)", tag, what, act, exp, m_h, m_line);
        end
    endtask

    // per-clock comparison against the reference model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1", "hpos", int'(hpos), m_h);
            chk("R1", "line_num", int'(line_num), m_line);
            chk("R2", "hblank", int'(hblank), int'(m_h >= 160));
            chk("R2", "hsync", int'(hsync), int'(m_h >= 176 && m_h < 192));
            chk("R3", "cpu_ce", int'(cpu_ce), int'(m_h % 3 == 2));
            chk("R4", "vsync", int'(vsync), int'(m_vs));
            chk("R6", "phase", int'(phase), exp_phase());
            chk("R6", "visible", int'(visible), int'(exp_phase() == 2));
            chk("R6", "vblank", int'(vblank), int'(exp_phase() != 2));
            chk("R7", "cpu_ready", int'(cpu_ready), int'(!m_halt));
        end
    end

    task automatic wait_h(int h);
        while (m_h != h) @(negedge clk);
    endtask

    task automatic pulse(bit sel, bit dat);
        wr_en = 1'b1; wr_sel = sel; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = 1'b0;
    endtask

    task automatic cpu_write(bit sel, bit dat);
        while (!(m_div == 2 && !m_halt)) @(negedge clk);
        pulse(sel, dat);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state (one clock after release, hpos has stepped once)
        chk("R10", "line_num", int'(line_num), 0);
        chk("R10", "vsync", int'(vsync), 0);
        chk("R10", "cpu_ready", int'(cpu_ready), 1);
        chk("R10", "phase", int'(phase), 1);
        chk("R10", "hpos", int'(hpos), 1);

        // R1: line advances at the wrap
        wait_h(0);
        chk("R1", "line after wrap", int'(line_num), 1);
        // R2: blanking and sync edges
        wait_h(159); chk("R2", "hblank at 159", int'(hblank), 0);
        @(negedge clk); chk("R2", "hblank at 160", int'(hblank), 1);
        wait_h(175); chk("R2", "hsync at 175", int'(hsync), 0);
        @(negedge clk); chk("R2", "hsync at 176", int'(hsync), 1);
        wait_h(192); chk("R2", "hsync at 192", int'(hsync), 0);
        // R3
        wait_h(2); chk("R3", "cpu_ce at 2", int'(cpu_ce), 1);

        // R4: start sync
        cpu_write(1'b0, 1'b1);
        chk("R4", "vsync set", int'(vsync), 1);
        chk("R6", "sync phase", int'(phase), 0);
        // R4: write without enable is ignored
        while (m_div != 0) @(negedge clk);
        pulse(1'b0, 1'b0);
        chk("R4", "no-ce write ignored", int'(vsync), 1);

        repeat (3 * 228) @(negedge clk);
        cpu_write(1'b0, 1'b0);
        chk("R5", "line reset on sync end", int'(line_num), 0);
        chk("R6", "vblank phase", int'(phase), 1);

        // R7: strobe mid-line
        wait_h(50);
        pulse(1'b1, 1'b0);
        chk("R7", "halted", int'(cpu_ready), 0);
        // R9: write while halted is ignored
        wait_h(101);
        pulse(1'b0, 1'b1);
        chk("R9", "vsync unchanged", int'(vsync), 0);
        wait_h(227); chk("R7", "still halted at 227", int'(cpu_ready), 0);
        @(negedge clk); chk("R7", "released at 0", int'(cpu_ready), 1);

        // R8: strobe on the last clock
        wait_h(227);
        pulse(1'b1, 1'b1);
        chk("R8", "halted at 0", int'(cpu_ready), 0);
        wait_h(227); chk("R8", "halted through line", int'(cpu_ready), 0);
        @(negedge clk); chk("R8", "released next line", int'(cpu_ready), 1);

        // R5: sync end on the last clock beats the increment
        cpu_write(1'b0, 1'b1);
        wait_h(227);
        pulse(1'b0, 1'b0);
        chk("R5", "line zero at wrap", int'(line_num), 0);
        chk("R5", "hpos at wrap", int'(hpos), 0);

        // R6: region boundaries
        while (m_line != 37) @(negedge clk);
        chk("R6", "visible at 37", int'(phase), 2);
        chk("R6", "visible flag", int'(visible), 1);
        while (m_line != 229) @(negedge clk);
        chk("R6", "overscan at 229", int'(phase), 3);
        chk("R6", "vblank in overscan", int'(vblank), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule